// File: doc/BRIEF.md
# Backlight PWM Generator with Committed Configuration

This block drives one pulse-width-modulated line for a display backlight. Software sets a clock prescaler, a period length and a high-time length through a small single-cycle register port. The output waveform repeats every (divider+1)·(period+1) clock cycles. In each repetition it is high for the first (divider+1)·(high+1) cycles. When the high value is at least the period value, the line stays high for the whole repetition.

The three timing fields are double-buffered. Writes only change the pending copies, so the output cannot see a configuration that is half written. A 0→1 transition of the commit bit snapshots the pending values. The snapshot reaches the running counters at the end of the current repetition, or on the next cycle if the output is disabled. A separate enable bit gates the generator. While it is clear, the output is low and the counters rest at zero. Setting it starts a fresh repetition with the line high.

Top module: `bl_pwm`

## Requirements
- R1: While the enable field (offset 0x00, bit 0) is 0, `pwm_out` is low from the second clock edge after the disabling write onward, and the prescaler and repetition counters rest at zero.
- R2: Offsets 0x00 (enable, bit 0), 0x08 (commit, bit 0), 0x10 (divider, bits 25:16) and 0x14 (period in bits 11:0, high in bits 28:16) read back their last written pending values one cycle after the address is presented. All other bits read 0 and ignore writes. Any other offset reads 0.
- R3: Writes to the divider, period or high fields do not change `pwm_out`. Only a 0→1 transition of the commit bit makes them effective, and writing 1 while the commit bit is already 1 has no effect.
- R4: With committed divider D and period P, one repetition of `pwm_out` lasts (D+1)·(P+1) clock cycles.
- R5: With committed high H < P, `pwm_out` is high for (D+1)·(H+1) cycles at the start of each repetition.
- R6: With H ≥ P, `pwm_out` stays high continuously while enabled.
- R7: A commit made while enabled lets the current repetition finish with the old values. The new values start at the next repetition.
- R8: A commit made while disabled takes effect at once, so the first repetition after enabling already uses it.
- R9: An enabling write starts a fresh repetition. `pwm_out` is still low at the first edge after the write and is high after the second edge.
- R10: After reset, every register reads 0 and `pwm_out` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| addr | input | ADDR_W | Byte offset of the register to write and read |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Registered read data for the previous cycle's addr |
| pwm_out | output | 1 | Registered PWM output |

## Verification
The assertions assume that at most one register is written per cycle and that the address is stable while the strobe is high. They also assume that reset is applied before any access. Under those assumptions the running counters never exceed the active limits. The bench drives every access for a full cycle from the falling edge and never overlaps two writes. It commits either while disabled or at a chosen point inside a high pulse, so that the deferred hand-over at the boundary is exercised deliberately.

// File: rtl/bl_pwm_pkg.sv
package bl_pwm_pkg;
  // Byte offsets decoded by software drivers
  localparam int OFS_ENABLE = 'h00;
  localparam int OFS_COMMIT = 'h08;
  localparam int OFS_DIV    = 'h10;
  localparam int OFS_SHAPE  = 'h14;
  // Field positions inside the data word
  localparam int EN_BIT     = 0;
  localparam int CMT_BIT    = 0;
  localparam int DIV_LSB    = 16;
  localparam int PER_LSB    = 0;
  localparam int HIGH_LSB   = 16;
endpackage

// File: rtl/bl_pwm_regs.sv
module bl_pwm_regs
  import bl_pwm_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int DIV_W  = 10,
  parameter int PER_W  = 12,
  parameter int HIGH_W = 13
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              en,
  output logic              commit_rise,
  output logic [DIV_W-1:0]  pend_div,
  output logic [PER_W-1:0]  pend_per,
  output logic [HIGH_W-1:0] pend_high
);
  localparam int TOP_USED = HIGH_LSB + HIGH_W;

  logic              en_q, cmt_q;
  logic [DIV_W-1:0]  div_q;
  logic [PER_W-1:0]  per_q;
  logic [HIGH_W-1:0] high_q;
  logic [DATA_W-1:0] rd_mux, rdata_q;
  logic sel_en, sel_cmt, sel_div, sel_shape;
  logic unused_wdata;

  assign sel_en    = (addr == ADDR_W'(OFS_ENABLE));
  assign sel_cmt   = (addr == ADDR_W'(OFS_COMMIT));
  assign sel_div   = (addr == ADDR_W'(OFS_DIV));
  assign sel_shape = (addr == ADDR_W'(OFS_SHAPE));
  assign unused_wdata = &{1'b0, wdata};

  assign commit_rise = wr_en && sel_cmt && wdata[CMT_BIT] && !cmt_q;

  always_comb begin
    rd_mux = '0;
    if (sel_en)  rd_mux[EN_BIT]  = en_q;
    if (sel_cmt) rd_mux[CMT_BIT] = cmt_q;
    if (sel_div) rd_mux[DIV_LSB +: DIV_W] = div_q;
    if (sel_shape) begin
      rd_mux[PER_LSB +: PER_W]   = per_q;
      rd_mux[HIGH_LSB +: HIGH_W] = high_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q    <= 1'b0;
      cmt_q   <= 1'b0;
      div_q   <= '0;
      per_q   <= '0;
      high_q  <= '0;
      rdata_q <= '0;
    end else begin
      rdata_q <= rd_mux;
      if (wr_en) begin
        if (sel_en)  en_q  <= wdata[EN_BIT];
        if (sel_cmt) cmt_q <= wdata[CMT_BIT];
        if (sel_div) div_q <= wdata[DIV_LSB +: DIV_W];
        if (sel_shape) begin
          per_q  <= wdata[PER_LSB +: PER_W];
          high_q <= wdata[HIGH_LSB +: HIGH_W];
        end
      end
    end
  end

  assign rdata     = rdata_q;
  assign en        = en_q;
  assign pend_div  = div_q;
  assign pend_per  = per_q;
  assign pend_high = high_q;

  // R3: a rising commit cannot repeat on the following cycle
  a_r3_single_rise: assert property (@(posedge clk) disable iff (rst)
    commit_rise |=> !commit_rise);
  // R2: bits above the widest field always read zero
  a_r2_top_zero: assert property (@(posedge clk) disable iff (rst)
    rdata[DATA_W-1:TOP_USED] == '0);
endmodule

// File: rtl/bl_pwm_shadow.sv
module bl_pwm_shadow #(
  parameter int DIV_W  = 10,
  parameter int PER_W  = 12,
  parameter int HIGH_W = 13
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              commit_rise,
  input  logic              boundary,
  input  logic [DIV_W-1:0]  pend_div,
  input  logic [PER_W-1:0]  pend_per,
  input  logic [HIGH_W-1:0] pend_high,
  output logic [DIV_W-1:0]  act_div,
  output logic [PER_W-1:0]  act_per,
  output logic [HIGH_W-1:0] act_high
);
  logic [DIV_W-1:0]  stg_div, act_div_q;
  logic [PER_W-1:0]  stg_per, act_per_q;
  logic [HIGH_W-1:0] stg_high, act_high_q;
  logic              waiting_q;
  logic              take;

  // hand-over happens at the repetition edge, or any time while idle
  assign take = waiting_q && (boundary || !en);

  always_ff @(posedge clk) begin
    if (rst) begin
      stg_div    <= '0;
      stg_per    <= '0;
      stg_high   <= '0;
      act_div_q  <= '0;
      act_per_q  <= '0;
      act_high_q <= '0;
      waiting_q  <= 1'b0;
    end else begin
      if (take) begin
        act_div_q  <= stg_div;
        act_per_q  <= stg_per;
        act_high_q <= stg_high;
      end
      if (commit_rise) begin
        stg_div   <= pend_div;
        stg_per   <= pend_per;
        stg_high  <= pend_high;
        waiting_q <= 1'b1;
      end else if (take) begin
        waiting_q <= 1'b0;
      end
    end
  end

  assign act_div  = act_div_q;
  assign act_per  = act_per_q;
  assign act_high = act_high_q;

  // R7: mid-repetition, the running values never move
  a_r7_hold_mid: assert property (@(posedge clk) disable iff (rst)
    (en && !boundary) |=> ($stable(act_div) && $stable(act_per) && $stable(act_high)));
  // R3: a commit always leaves a snapshot waiting
  a_r3_arm: assert property (@(posedge clk) disable iff (rst)
    commit_rise |=> waiting_q);
  // R8: while idle a waiting snapshot is consumed on the next edge
  a_r8_idle_take: assert property (@(posedge clk) disable iff (rst)
    (waiting_q && !en && !commit_rise) |=> !waiting_q);
endmodule

// File: rtl/bl_pwm_gen.sv
module bl_pwm_gen #(
  parameter int DIV_W  = 10,
  parameter int PER_W  = 12,
  parameter int HIGH_W = 13
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [DIV_W-1:0]  act_div,
  input  logic [PER_W-1:0]  act_per,
  input  logic [HIGH_W-1:0] act_high,
  output logic              boundary,
  output logic              pwm_out
);
  logic [DIV_W-1:0] pre_q;
  logic [PER_W-1:0] cnt_q;
  logic             out_q;
  logic             tick;

  assign tick     = en && (pre_q == act_div);
  assign boundary = tick && (cnt_q == act_per);

  always_ff @(posedge clk) begin
    if (rst) begin
      pre_q <= '0;
      cnt_q <= '0;
      out_q <= 1'b0;
    end else begin
      out_q <= en && (HIGH_W'(cnt_q) <= act_high);
      if (!en) begin
        pre_q <= '0;
        cnt_q <= '0;
      end else if (tick) begin
        pre_q <= '0;
        cnt_q <= boundary ? '0 : cnt_q + 1'b1;
      end else begin
        pre_q <= pre_q + 1'b1;
      end
    end
  end

  assign pwm_out = out_q;

  // R1: disabled generator gives a low line and parked counters
  a_r1_off_low: assert property (@(posedge clk) disable iff (rst)
    !en |=> !pwm_out);
  a_r1_parked: assert property (@(posedge clk) disable iff (rst)
    !en |=> (pre_q == '0 && cnt_q == '0));
  // R4: counters stay inside the active limits
  a_r4_in_range: assert property (@(posedge clk) disable iff (rst)
    en |-> (cnt_q <= act_per && pre_q <= act_div));
  // R6: high not below period keeps the line up
  a_r6_full_on: assert property (@(posedge clk) disable iff (rst)
    (en && act_high >= HIGH_W'(act_per)) |=> pwm_out);
  // R9: enabling begins with a high output
  a_r9_start_high: assert property (@(posedge clk) disable iff (rst)
    $rose(en) |=> pwm_out);
endmodule

// File: rtl/bl_pwm.sv
module bl_pwm #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int DIV_W  = 10,
  parameter int PER_W  = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              pwm_out
);
  // one extra high bit so high can exceed period (full duty)
  localparam int HIGH_W = PER_W + 1;

  logic              en, commit_rise, boundary;
  logic [DIV_W-1:0]  pend_div, act_div;
  logic [PER_W-1:0]  pend_per, act_per;
  logic [HIGH_W-1:0] pend_high, act_high;

  bl_pwm_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .DIV_W(DIV_W), .PER_W(PER_W), .HIGH_W(HIGH_W)
  ) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .en(en), .commit_rise(commit_rise),
    .pend_div(pend_div), .pend_per(pend_per), .pend_high(pend_high)
  );

  bl_pwm_shadow #(
    .DIV_W(DIV_W), .PER_W(PER_W), .HIGH_W(HIGH_W)
  ) u_shadow (
    .clk(clk), .rst(rst), .en(en), .commit_rise(commit_rise),
    .boundary(boundary),
    .pend_div(pend_div), .pend_per(pend_per), .pend_high(pend_high),
    .act_div(act_div), .act_per(act_per), .act_high(act_high)
  );

  bl_pwm_gen #(
    .DIV_W(DIV_W), .PER_W(PER_W), .HIGH_W(HIGH_W)
  ) u_gen (
    .clk(clk), .rst(rst), .en(en),
    .act_div(act_div), .act_per(act_per), .act_high(act_high),
    .boundary(boundary), .pwm_out(pwm_out)
  );
endmodule

// File: tb/test_bl_pwm.sv
`timescale 1ns/1ps
module test_bl_pwm;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        pwm_out;

  always #2 clk = ~clk;

  bl_pwm #(.ADDR_W(8), .DATA_W(32), .DIV_W(10), .PER_W(12)) i_bl_pwm (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .pwm_out(pwm_out)
  );

  int total = 0, bad = 0, cyc = 0;
  bit done = 0;
  string tag = "R10";

  // behavioural reference state
  int m_en, m_cmt, m_div, m_per, m_hi, s_div, s_per, s_hi, m_wait;
  int a_div, a_per, a_hi, m_pre, m_cnt, m_out, m_rd;

  function automatic int rd_of(int a);
    case (a)
      'h00: return m_en;
      'h08: return m_cmt;
      'h10: return m_div << 16;
      'h14: return (m_hi << 16) | m_per;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin : model
    int n_out, tick, bnd, ld, rise;
    if (rst) begin
      m_en = 0; m_cmt = 0; m_div = 0; m_per = 0; m_hi = 0;
      s_div = 0; s_per = 0; s_hi = 0; m_wait = 0;
      a_div = 0; a_per = 0; a_hi = 0; m_pre = 0; m_cnt = 0; m_out = 0; m_rd = 0;
    end else begin
      n_out = (m_en != 0 && m_cnt <= a_hi) ? 1 : 0;
      tick  = (m_en != 0 && m_pre == a_div) ? 1 : 0;
      bnd   = (tick != 0 && m_cnt == a_per) ? 1 : 0;
      ld    = (m_wait != 0 && (bnd != 0 || m_en == 0)) ? 1 : 0;
      rise  = (wr_en && addr == 8'h08 && wdata[0] && m_cmt == 0) ? 1 : 0;
      m_rd  = rd_of(int'(addr));
      if (m_en == 0) begin m_pre = 0; m_cnt = 0; end
      else if (tick != 0) begin m_pre = 0; m_cnt = (bnd != 0) ? 0 : m_cnt + 1; end
      else m_pre = m_pre + 1;
      if (ld != 0) begin a_div = s_div; a_per = s_per; a_hi = s_hi; end
      if (rise != 0) begin s_div = m_div; s_per = m_per; s_hi = m_hi; m_wait = 1; end
      else if (ld != 0) m_wait = 0;
      if (wr_en) begin
        case (addr)
          8'h00: m_en  = int'(wdata[0]);
          8'h08: m_cmt = int'(wdata[0]);
          8'h10: m_div = int'(wdata[25:16]);
          8'h14: begin m_per = int'(wdata[11:0]); m_hi = int'(wdata[28:16]); end
          default: ;
        endcase
      end
      m_out = n_out;
    end
  end

  task automatic chk(string r, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", r, what, act, exp);
    end
  endtask

  // compare against the reference on every cycle
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk(tag, "pwm_out vs model", int'(pwm_out), m_out);
      chk(tag, "rdata vs model", int'(rdata), m_rd);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      bad++; total++;
      $display("FAIL R4 watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic wr(int a, logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = 8'(a); wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd_chk(string r, int a, int exp);
    @(negedge clk); addr = 8'(a);
    @(negedge clk); chk(r, "readback", int'(rdata), exp);
  endtask

  task automatic commit();
    wr('h08, 32'd1); wr('h08, 32'd0);
  endtask

  task automatic enable_exact();
    @(negedge clk); wr_en = 1'b1; addr = 8'h00; wdata = 32'd1;
    @(negedge clk); wr_en = 1'b0;
    chk("R9", "out one edge after enable", int'(pwm_out), 0);
    @(negedge clk);
    chk("R9", "out two edges after enable", int'(pwm_out), 1);
  endtask

  task automatic measure(output int hi, output int per);
    int lo;
    do @(negedge clk); while (pwm_out);
    do @(negedge clk); while (!pwm_out);
    hi = 0;
    while (pwm_out) begin hi++; @(negedge clk); end
    lo = 0;
    while (!pwm_out) begin lo++; @(negedge clk); end
    per = hi + lo;
  endtask

  task automatic lows_over(int n, output int lows);
    lows = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (!pwm_out) lows++;
    end
  endtask

  initial begin
    int hi, pr, lows;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R10: reset state
    chk("R10", "out after reset", int'(pwm_out), 0);
    rd_chk("R10", 'h00, 0); rd_chk("R10", 'h08, 0);
    rd_chk("R10", 'h10, 0); rd_chk("R10", 'h14, 0);

    // R2: field masks, unmapped offset
    tag = "R2";
    wr('h10, 32'hFFFF_FFFF); rd_chk("R2", 'h10, 32'h03FF_0000);
    wr('h14, 32'hFFFF_FFFF); rd_chk("R2", 'h14, 32'h1FFF_0FFF);
    wr('h04, 32'hFFFF_FFFF); rd_chk("R2", 'h04, 0);
    wr('h10, 32'h0002_0000); wr('h14, 32'h0004_0009);
    rd_chk("R2", 'h14, 32'h0004_0009);

    // R8: commit while disabled, then R9 exact start
    tag = "R8";
    commit();
    enable_exact();
    measure(hi, pr);
    chk("R8", "high after idle commit", hi, 15);
    chk("R4", "period div2 per9", pr, 30);
    chk("R5", "high div2 hi4", hi, 15);

    // R3: pending writes alone change nothing
    tag = "R3";
    wr('h14, 32'h0007_0009);
    measure(hi, pr);
    chk("R3", "high before commit", hi, 15);
    wr('h08, 32'd1);
    rd_chk("R2", 'h08, 1);
    measure(hi, pr);
    chk("R5", "high div2 hi7", hi, 24);
    wr('h14, 32'h0001_0009);
    wr('h08, 32'd1);
    measure(hi, pr);
    chk("R3", "repeat 1 to commit ignored", hi, 24);
    wr('h08, 32'd0);

    // R7: commit inside a high pulse, old pulse finishes
    tag = "R7";
    wr('h10, 32'h0000_0000); wr('h14, 32'h0002_0013);
    do @(negedge clk); while (pwm_out);
    do @(negedge clk); while (!pwm_out);
    hi = 1;
    wr('h08, 32'd1);
    hi += 2;
    while (1) begin
      @(negedge clk);
      if (!pwm_out) break;
      hi++;
    end
    chk("R7", "pulse in progress keeps old length", hi, 24);
    measure(hi, pr);
    chk("R7", "next pulse uses new high", hi, 3);
    chk("R4", "period div0 per19", pr, 20);
    wr('h08, 32'd0);

    // R6: high above and equal to period
    tag = "R6";
    wr('h14, 32'h000C_0009); commit();
    repeat (30) @(negedge clk);
    lows_over(60, lows);
    chk("R6", "lows with hi>per", lows, 0);
    wr('h14, 32'h0009_0009); commit();
    repeat (30) @(negedge clk);
    lows_over(60, lows);
    chk("R6", "lows with hi==per", lows, 0);

    // R1: disable forces low
    tag = "R1";
    wr('h00, 32'd0);
    @(negedge clk);
    lows_over(20, lows);
    chk("R1", "lows while disabled", lows, 20);

    // R8/R9/R5: shortest split waveform after re-enable
    tag = "R9";
    wr('h14, 32'h0000_0001); commit();
    enable_exact();
    measure(hi, pr);
    chk("R5", "high div0 hi0", hi, 1);
    chk("R4", "period div0 per1", pr, 2);

    // R6 corner: everything zero
    tag = "R6";
    wr('h14, 32'h0000_0000); commit();
    repeat (8) @(negedge clk);
    lows_over(20, lows);
    chk("R6", "lows with all zero", lows, 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule